// File: doc/BRIEF.md
# Dual-Chamber Tracking Pacing Timer

This block times atrial and ventricular stimulation for a dual-chamber pacing scheme in which the ventricle tracks the atrium. It reads two sense inputs, one per chamber, and a one-clock strobe that arrives once per millisecond. It produces one-clock pace pulses for each chamber. Three 12-bit millisecond values set the timing: the lower-rate interval (LRI), the upper-rate interval (URI) and the atrio-ventricular delay (AVD).

Each chamber has its own sense-enable flag. A sense is accepted only while its chamber's flag is set. An accepted sense produces that chamber's pace event at once. The sequence is:

- After reset, the block waits up to LRI for a ventricular event.
- Every ventricular event, sensed or paced, starts a URI hold-off with both chambers deaf.
- When the hold-off ends, an atrial window of LRI − AVD − URI opens. If no atrial sense arrives in it, the atrium is paced when it closes.
- Every atrial event starts the AV delay. The ventricle is paced when the delay runs out, unless a ventricular sense comes first.

Top module: `dual_chamber_pacer`

## Requirements
- R1: While `rst` is high and on the first clock after it, `pace_atr`, `pace_ven` and `cfg_err` are 0. After reset the block is in its first cycle with ventricular sensing on and atrial sensing off. With no sense, the first `pace_ven` follows exactly LRI ticks after reset is released.
- R2: In the first cycle, a ventricular sense accepted after k ticks (k < LRI) yields `pace_ven` with the tick count at k. Atrial senses in the first cycle are discarded.
- R3: Every ventricular event clears both sense enables. For the next URI ticks, senses in either chamber are discarded.
- R4: The atrial window opens on the URI-th tick after a ventricular event, with atrial sensing enabled alone. An accepted atrial sense ends the window with `pace_atr`. Otherwise `pace_atr` comes on the (LRI − AVD − URI)-th tick of the window. Ventricular senses inside the window are discarded.
- R5: An atrial event disables atrial sensing and enables ventricular sensing. A ventricular sense accepted after k < AVD ticks yields `pace_ven` at k. Otherwise `pace_ven` comes on the AVD-th tick. Atrial senses in this phase are discarded.
- R6: Each pace pulse is one clock wide. It appears on the clock after the edge that samples the accepted sense or the terminal tick. A sense and the terminal tick in the same clock give exactly one pace, and the next phase is timed from it.
- R7: `pace_atr` and `pace_ven` are never 1 in the same clock.
- R8: `cfg_err` is registered and becomes 1 one clock after the inputs satisfy LRI <= AVD + URI, and 0 otherwise. While it is 1, the atrial window length is taken as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-clock strobe per millisecond; all timers count these |
| sense_atr | input | 1 | Atrial sense, sampled every clock |
| sense_ven | input | 1 | Ventricular sense, sampled every clock |
| lri_ms | input | TW | Lower-rate interval in ms |
| uri_ms | input | TW | Upper-rate interval in ms |
| avd_ms | input | TW | Atrio-ventricular delay in ms |
| pace_atr | output | 1 | Atrial pace pulse, one clock wide |
| pace_ven | output | 1 | Ventricular pace pulse, one clock wide |
| cfg_err | output | 1 | Timing values inconsistent (LRI <= AVD + URI) |

## Verification
The AV-delay expiry and the acceptance of a ventricular sense can fall in the same clock. Both lead to the same ventricular pace. The bench provokes the collision by raising the ventricular sense in the very clock that carries the AVD-th tick. It then requires one pace at an interval of exactly AVD, followed by an atrial pace URI + LRI − AVD − URI ticks later. A second pace or a shifted interval would expose double firing or a timer that restarted on the wrong edge. A related collision is both senses arriving together during the AV delay. There only the ventricular pace may appear.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

  // Pacing phases, in the order a normal cardiac cycle visits them
  typedef enum logic [1:0] {
    PH_FIRST = 2'd0,  // initial cycle: wait LRI for a ventricular event
    PH_REFR  = 2'd1,  // hold-off after a ventricular event, both chambers deaf
    PH_AWIN  = 2'd2,  // atrial escape window
    PH_AVDLY = 2'd3   // atrio-ventricular delay
  } phase_e;

endpackage

// File: rtl/dcp_interval_timer.sv
module dcp_interval_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          restart,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  localparam int CW = TW + 1;

  logic [CW-1:0] elapsed;
  logic [CW-1:0] elapsed_inc;

  assign elapsed_inc = elapsed + CW'(1);
  // The terminal tick is the one that brings the count up to the limit
  assign expire = tick && (elapsed_inc >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      elapsed <= '0;
    end else if (tick && (elapsed != '1)) begin
      elapsed <= elapsed_inc;
    end
  end

endmodule

// File: rtl/dcp_window_calc.sv
module dcp_window_calc #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] lri,
  input  logic [TW-1:0] uri,
  input  logic [TW-1:0] avd,
  output logic [TW-1:0] awin,
  output logic          cfg_err
);
  localparam int XW = TW + 2;

  logic [XW-1:0] used;
  logic [XW-1:0] remain;
  logic          bad;

  assign used   = XW'(avd) + XW'(uri);
  assign remain = XW'(lri) - used;
  assign bad    = (XW'(lri) <= used);

  always_ff @(posedge clk) begin
    if (rst) begin
      awin    <= '0;
      cfg_err <= 1'b0;
    end else begin
      awin    <= bad ? '0 : remain[TW-1:0];
      cfg_err <= bad;
    end
  end

endmodule

// File: rtl/dcp_sense_gate.sv
module dcp_sense_gate (
  input  logic clk,
  input  logic rst,
  input  logic sense_a,
  input  logic sense_v,
  input  logic v_event,
  input  logic a_event,
  input  logic a_reopen,
  output logic acc_a,
  output logic acc_v,
  output logic sa_en,
  output logic sv_en
);

  assign acc_a = sense_a && sa_en;
  assign acc_v = sense_v && sv_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      sa_en <= 1'b0;
      sv_en <= 1'b1;
    end else if (v_event) begin
      sa_en <= 1'b0;
      sv_en <= 1'b0;
    end else if (a_event) begin
      sa_en <= 1'b0;
      sv_en <= 1'b1;
    end else if (a_reopen) begin
      sa_en <= 1'b1;
    end
  end

endmodule

// File: rtl/dcp_sequencer.sv
module dcp_sequencer
  import dcp_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_a,
  input  logic          acc_v,
  input  logic          expire,
  input  logic [TW-1:0] lri,
  input  logic [TW-1:0] uri,
  input  logic [TW-1:0] avd,
  input  logic [TW-1:0] awin,
  output logic [TW-1:0] limit,
  output logic          restart,
  output logic          fire_a,
  output logic          fire_v,
  output logic          reopen_a,
  output phase_e        phase,
  output logic          pace_a,
  output logic          pace_v
);

  phase_e phase_nxt;

  always_comb begin
    case (phase)
      PH_FIRST: limit = lri;
      PH_REFR:  limit = uri;
      PH_AWIN:  limit = awin;
      default:  limit = avd;
    endcase
  end

  always_comb begin
    fire_v    = 1'b0;
    fire_a    = 1'b0;
    reopen_a  = 1'b0;
    phase_nxt = phase;
    case (phase)
      PH_FIRST, PH_AVDLY: begin
        if (acc_v || expire) begin
          fire_v    = 1'b1;
          phase_nxt = PH_REFR;
        end
      end
      PH_REFR: begin
        if (expire) begin
          reopen_a  = 1'b1;
          phase_nxt = PH_AWIN;
        end
      end
      default: begin
        if (acc_a || expire) begin
          fire_a    = 1'b1;
          phase_nxt = PH_AVDLY;
        end
      end
    endcase
  end

  assign restart = fire_a || fire_v || reopen_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_FIRST;
      pace_a <= 1'b0;
      pace_v <= 1'b0;
    end else begin
      phase  <= phase_nxt;
      pace_a <= fire_a;
      pace_v <= fire_v;
    end
  end

endmodule

// File: rtl/dual_chamber_pacer.sv
module dual_chamber_pacer
  import dcp_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_ms,
  input  logic          sense_atr,
  input  logic          sense_ven,
  input  logic [TW-1:0] lri_ms,
  input  logic [TW-1:0] uri_ms,
  input  logic [TW-1:0] avd_ms,
  output logic          pace_atr,
  output logic          pace_ven,
  output logic          cfg_err
);

  logic          acc_a;
  logic          acc_v;
  logic          sa_en;
  logic          sv_en;
  logic          expire;
  logic          restart;
  logic          fire_a;
  logic          fire_v;
  logic          reopen_a;
  logic [TW-1:0] limit;
  logic [TW-1:0] awin;
  phase_e        phase;

  dcp_window_calc #(.TW(TW)) u_win (
    .clk     (clk),
    .rst     (rst),
    .lri     (lri_ms),
    .uri     (uri_ms),
    .avd     (avd_ms),
    .awin    (awin),
    .cfg_err (cfg_err)
  );

  dcp_sense_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .sense_a  (sense_atr),
    .sense_v  (sense_ven),
    .v_event  (fire_v),
    .a_event  (fire_a),
    .a_reopen (reopen_a),
    .acc_a    (acc_a),
    .acc_v    (acc_v),
    .sa_en    (sa_en),
    .sv_en    (sv_en)
  );

  dcp_interval_timer #(.TW(TW)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_ms),
    .restart (restart),
    .limit   (limit),
    .expire  (expire)
  );

  dcp_sequencer #(.TW(TW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .acc_a    (acc_a),
    .acc_v    (acc_v),
    .expire   (expire),
    .lri      (lri_ms),
    .uri      (uri_ms),
    .avd      (avd_ms),
    .awin     (awin),
    .limit    (limit),
    .restart  (restart),
    .fire_a   (fire_a),
    .fire_v   (fire_v),
    .reopen_a (reopen_a),
    .phase    (phase),
    .pace_a   (pace_atr),
    .pace_v   (pace_ven)
  );

endmodule

// File: rtl/dcp_checker.sv
module dcp_checker
  import dcp_pkg::*;
#(
  parameter int TW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          pace_atr,
  input logic          pace_ven,
  input logic          cfg_err,
  input logic          sa_en,
  input logic          sv_en,
  input phase_e        phase,
  input logic [TW-1:0] lri_ms,
  input logic [TW-1:0] uri_ms,
  input logic [TW-1:0] avd_ms
);

  AST_PACE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pace_atr && pace_ven)); // R7

  AST_APULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    pace_atr |=> !pace_atr); // R6

  AST_VPULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    pace_ven |=> !pace_ven); // R6

  AST_FIRST_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FIRST) |-> (!sa_en && sv_en)); // R2

  AST_REFR_DEAF: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_REFR) |-> (!sa_en && !sv_en)); // R3

  AST_VPACE_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
    pace_ven |-> (phase == PH_REFR)); // R3

  AST_AWIN_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_AWIN) |-> (sa_en && !sv_en)); // R4

  AST_AVD_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_AVDLY) |-> (!sa_en && sv_en)); // R5

  AST_APACE_TRACK: assert property (@(posedge clk) disable iff (rst)
    pace_atr |-> (phase == PH_AVDLY)); // R5

  AST_CFG_FLAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cfg_err ==
      ({2'b00, $past(lri_ms)} <= ({2'b00, $past(avd_ms)} + {2'b00, $past(uri_ms)})))); // R8

endmodule

bind dual_chamber_pacer dcp_checker #(.TW(TW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pace_atr (pace_atr),
  .pace_ven (pace_ven),
  .cfg_err  (cfg_err),
  .sa_en    (sa_en),
  .sv_en    (sv_en),
  .phase    (phase),
  .lri_ms   (lri_ms),
  .uri_ms   (uri_ms),
  .avd_ms   (avd_ms)
);

// File: tb/sim_dual_chamber_pacer.sv
`timescale 1ns/1ps
module sim_dual_chamber_pacer;

  localparam int TW   = 12;
  localparam int TDIV = 4;
  localparam int LRI  = 40;
  localparam int URI  = 10;
  localparam int AVD  = 8;
  localparam int AWIN = LRI - AVD - URI;  // 22

  // step = {inject[1:0], k[7:0], exp_chamber[1:0], exp_interval[7:0]}
  // inject: 0 none, 1 atrial, 2 ventricular, 3 both ; chamber: 1 atrial, 2 ventricular
  localparam int NSTEP = 14;
  localparam logic [19:0] STEPS [NSTEP] = '{
    {2'd0, 8'd0,  2'd2, 8'(LRI)},        // R1 first V pace at LRI
    {2'd1, 8'd3,  2'd1, 8'(URI + AWIN)}, // R3 atrial sense in hold-off ignored
    {2'd0, 8'd0,  2'd2, 8'(AVD)},        // R5 AV delay expiry
    {2'd0, 8'd0,  2'd1, 8'(URI + AWIN)}, // R4 atrial window expiry
    {2'd1, 8'd5,  2'd2, 8'(AVD)},        // R5 atrial sense during AVD ignored
    {2'd1, 8'd15, 2'd1, 8'd15},          // R4 atrial sense accepted
    {2'd2, 8'd3,  2'd2, 8'd3},           // R5 ventricular sense accepted
    {2'd2, 8'd20, 2'd1, 8'(URI + AWIN)}, // R4 ventricular sense in window ignored
    {2'd3, 8'd4,  2'd2, 8'd4},           // R5 both senses: ventricular only
    {2'd2, 8'd5,  2'd1, 8'(URI + AWIN)}, // R3 ventricular sense in hold-off ignored
    {2'd0, 8'd0,  2'd2, 8'(AVD)},        // R5
    {2'd1, 8'd10, 2'd1, 8'(URI)},        // R4 sense right as window opens
    {2'd0, 8'd0,  2'd2, 8'(AVD)},        // R5
    {2'd1, 8'(URI - 1), 2'd1, 8'(URI + AWIN)} // R3 last hold-off tick still deaf
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_ms = 1'b0;
  logic          sense_atr = 1'b0;
  logic          sense_v_tb = 1'b0;
  logic          sense_v_sync = 1'b0;
  logic          sync_req = 1'b0;
  logic          sense_ven;
  logic [TW-1:0] lri_ms = TW'(LRI);
  logic [TW-1:0] uri_ms = TW'(URI);
  logic [TW-1:0] avd_ms = TW'(AVD);
  logic          pace_atr;
  logic          pace_ven;
  logic          cfg_err;

  int checks = 0;
  int errors = 0;
  int tcnt = 0;
  int ev_n = 0;
  int ev_ch = 0;
  int ev_int = 0;
  int overlap = 0;
  bit done = 1'b0;

  assign sense_ven = sense_v_tb | sense_v_sync;

  always #2.5 clk = ~clk;

  dual_chamber_pacer #(.TW(TW)) u0 (
    .clk       (clk),
    .rst       (rst),
    .tick_ms   (tick_ms),
    .sense_atr (sense_atr),
    .sense_ven (sense_ven),
    .lri_ms    (lri_ms),
    .uri_ms    (uri_ms),
    .avd_ms    (avd_ms),
    .pace_atr  (pace_atr),
    .pace_ven  (pace_ven),
    .cfg_err   (cfg_err)
  );

  // millisecond strobe, optionally carrying a ventricular sense in the same clock
  initial begin
    forever begin
      repeat (TDIV - 1) @(posedge clk);
      #1;
      tick_ms = 1'b1;
      if (sync_req) begin
        sense_v_sync = 1'b1;
        sync_req = 1'b0;
      end
      @(posedge clk);
      #1;
      tick_ms = 1'b0;
      sense_v_sync = 1'b0;
    end
  end

  // pace monitor: ticks between pace events
  always @(negedge clk) begin
    if (rst) begin
      tcnt = 0;
    end else begin
      if (pace_atr || pace_ven) begin
        ev_ch  = pace_atr ? 1 : 2;
        ev_int = tcnt;
        tcnt   = 0;
        ev_n   = ev_n + 1;
        if (pace_atr && pace_ven) overlap = overlap + 1;
      end
      if (tick_ms) tcnt = tcnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int k);
    do begin
      @(negedge clk);
      #0.5;
    end while (tcnt != k);
  endtask

  task automatic pulse_sense(input logic [1:0] which);
    @(posedge clk);
    #1;
    sense_atr  = which[0];
    sense_v_tb = which[1];
    @(posedge clk);
    #1;
    sense_atr  = 1'b0;
    sense_v_tb = 1'b0;
  endtask

  task automatic expect_event(input int n0, input int ch, input int itv, input string req);
    int guard;
    guard = 0;
    while (ev_n == n0 && guard < 2000) begin
      @(negedge clk);
      #0.5;
      guard = guard + 1;
    end
    if (ev_n == n0) begin
      check(1'b0, req, 0, ch);
    end else begin
      check(ev_ch == ch, req, ev_ch, ch);
      check(ev_int == itv, req, ev_int, itv);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(pace_atr == 1'b0, "R1", int'(pace_atr), 0);
    check(pace_ven == 1'b0, "R1", int'(pace_ven), 0);
    check(cfg_err == 1'b0, "R1", int'(cfg_err), 0);
    @(posedge clk);
    #1;
    rst = 1'b0;

    for (int s = 0; s < NSTEP; s++) begin
      logic [19:0] st;
      int n0;
      st = STEPS[s];
      n0 = ev_n;
      if (st[19:18] != 2'd0) begin
        wait_ticks(int'(st[17:10]));
        pulse_sense(st[19:18]);
      end
      expect_event(n0, int'(st[9:8]), int'(st[7:0]), $sformatf("step%0d", s));
    end

    // R6 sense on the terminal AVD tick: one pace, timing unchanged
    begin
      int n0;
      n0 = ev_n;
      wait_ticks(AVD - 1);
      sync_req = 1'b1;
      expect_event(n0, 2, AVD, "R6");
      n0 = ev_n;
      expect_event(n0, 1, URI + AWIN, "R6");
    end

    // R2 first cycle: atrial sense ignored, ventricular sense accepted
    @(posedge clk);
    #1;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    begin
      int n0;
      n0 = ev_n;
      wait_ticks(5);
      pulse_sense(2'b01);
      wait_ticks(12);
      pulse_sense(2'b10);
      expect_event(n0, 2, 12, "R2");
    end

    // R7 no clock ever carried both pace outputs
    check(overlap == 0, "R7", overlap, 0);

    // R8 configuration consistency flag
    @(posedge clk);
    #1;
    lri_ms = TW'(31); uri_ms = TW'(10); avd_ms = TW'(20);
    @(posedge clk);
    @(negedge clk);
    check(cfg_err == 1'b0, "R8", int'(cfg_err), 0);
    @(posedge clk);
    #1;
    lri_ms = TW'(30);
    @(posedge clk);
    @(negedge clk);
    check(cfg_err == 1'b1, "R8", int'(cfg_err), 1);
    @(posedge clk);
    #1;
    lri_ms = TW'(12);
    @(posedge clk);
    @(negedge clk);
    check(cfg_err == 1'b1, "R8", int'(cfg_err), 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule